// File: doc/BRIEF.md
# LPC Flash Target Access Gate

This block sits at the bus edge of a small flash target on a low-pin-count host bus. It decides whether a bus frame may begin, classifies the 32-bit cycle address as array space, register space or foreign, and decides whether a program or erase request may go on to the array. The decision uses two active-low hardware lock pins. One lock covers the top boot block. The other covers every sector outside that block.

An upstream frame parser supplies the following inputs:

- a decoded address with a valid strobe;
- a program/erase request;
- an end-of-cycle strobe;
- a request to drive read data.

The flash engine reports the end of an internal write with `op_done`. Either of the two reset pins drops the block to its idle state and releases the data lines. A reset that lands on an unfinished write is reported with an abort pulse.

The control is a three-state machine.

- **STANDBY**: idle.
  - A valid frame start (*frame-go*) moves it to ACTIVE.
- **ACTIVE**: a bus cycle is open.
  - A new frame start restarts the cycle (*restart*) and stays in ACTIVE.
  - An address outside both windows returns to STANDBY (*decode-miss*).
  - A permitted program/erase request moves to WRITING (*accept*).
  - A locked request returns to STANDBY (*reject*).
  - The parser's end strobe returns to STANDBY (*cycle-end*).
- **WRITING**: an internal write is in progress.
  - `op_done` returns to STANDBY (*write-done*).
- **Reset**: forces STANDBY from any state.

Top module: `lpc_access_gate`

## Requirements
- R1: A frame start is recognised (`cyc_start` high, combinationally, in that clock) only if `ce_n` was sampled low on the clock edge before the clock in which `lframe_n` first went low. If it was not, the whole frame is ignored, even while `lframe_n` stays low.
- R2: The start code is LAD = 4'b0000. Any other LAD value gives no start. A start code that arrives in a later clock of the same low-`lframe_n` frame still starts the cycle.
- R3: The block uses `addr_in[31:22]` for the window decode.
  - Address bits [31:22] = 10'h3FF (0xFFC00000 to 0xFFFFFFFF) set `mem_sel`.
  - Address bits [31:22] = 10'h3FE (0xFF800000 to 0xFFBFFFFF) set `reg_sel`.
  - The flag is visible in the clock after `addr_vld`.
  - Any other address drops the cycle to STANDBY, and a following `op_req` then has no effect.
  - `op_req` counts only in ACTIVE with `mem_sel` set. In register space it produces neither grant nor reject.
- R4: Array offsets `addr_in[17:14]` = 4'b1111 (0x3C000 to 0x3FFFF, any alias in the window) form the top boot block. A request there is rejected while `tbl_n` is low, whatever `wp_n` is.
- R5: A request at any other offset is rejected while `wp_n` is low, whatever `tbl_n` is.
- R6: A permitted request gives a one-clock `op_grant` pulse in the clock after `op_req` and enters WRITING. While WRITING:
  - frame starts are ignored;
  - changes on `tbl_n` and `wp_n` produce no reject and no abort;
  - the block stays out of standby until `op_done`.
- R7: A locked request gives a one-clock `op_reject` pulse in the clock after `op_req`, never together with `op_grant`, and returns to STANDBY.
- R8: A frame start while ACTIVE restarts the cycle and clears both select flags at that edge.
- R9: `init_n` and `rst_n` act alike. Either one low forces `lad_oe` low at once. At the next edge it returns the block to STANDBY and clears the select flags. Release is synchronised through two flops, so the block operates from the third edge after release.
- R10: `op_abort` pulses for one clock after the reset edge if the block was WRITING. It stays low if `op_done` was high in that same clock.
- R11: `standby` is high exactly when the state is STANDBY and `ce_n` is high.
- R12: `lad_oe` follows `drv_req` only while ACTIVE with a select flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| ce_n | input | 1 | Chip enable, active low |
| lframe_n | input | 1 | Frame marker, active low |
| lad_in | input | 4 | Bus address/data lines, input side |
| init_n | input | 1 | Initialisation reset, active low |
| rst_n | input | 1 | System reset, active low |
| tbl_n | input | 1 | Top boot block lock, active low |
| wp_n | input | 1 | Main sector lock, active low |
| addr_in | input | 32 | Cycle address from the frame parser |
| addr_vld | input | 1 | `addr_in` is valid this clock |
| op_req | input | 1 | Program/erase request |
| op_done | input | 1 | Internal write finished |
| cyc_end | input | 1 | Parser reports end of the bus cycle |
| drv_req | input | 1 | Parser wants to drive read data on LAD |
| cyc_start | output | 1 | Valid frame start this clock |
| mem_sel | output | 1 | Cycle targets the array window |
| reg_sel | output | 1 | Cycle targets the register window |
| op_grant | output | 1 | One-clock program/erase permit |
| op_reject | output | 1 | One-clock program/erase refusal |
| op_abort | output | 1 | One-clock pulse: write cut short by reset |
| lad_oe | output | 1 | LAD output enable |
| standby | output | 1 | Idle with chip enable high |

## Verification
A reset can arrive in the very clock in which the flash engine raises `op_done`. In that case write completion and write abort compete for the same edge. The bench provokes this by lowering `rst_n` in the same low clock phase that raises `op_done` during WRITING. It expects `op_abort` to stay low, and it runs the same sequence with `op_done` held low, where it expects a single abort pulse. A second collision, a frame start during WRITING together with lock pin changes, is judged by the absence of `cyc_start`, `op_reject` and `op_abort`.

// File: rtl/lpc_gate_pkg.sv
`timescale 1ns/1ps
package lpc_gate_pkg;
    localparam logic [3:0] LAD_START = 4'b0000;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_WRITING = 2'd2
    } gate_state_t;
endpackage

// File: rtl/lpc_rst_sync.sv
`timescale 1ns/1ps
// Immediate assertion, release after STAGES clock edges.
module lpc_rst_sync #(
    parameter int STAGES = 2
)(
    input  logic clk,
    input  logic init_n,
    input  logic rst_n,
    output logic rst_o
);
    logic             rst_raw;
    logic [STAGES-1:0] chain;

    assign rst_raw = ~(init_n & rst_n);

    always_ff @(posedge clk or posedge rst_raw) begin
        if (rst_raw) chain <= '1;
        else         chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/lpc_start_detect.sv
`timescale 1ns/1ps
module lpc_start_detect
    import lpc_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       lframe_n,
    input  logic [3:0] lad_in,
    output logic       start
);
    logic ce_q, lf_q, ok_q, ok_now;

    // Chip enable must lead the frame's first low clock by one edge.
    assign ok_now = lf_q ? ~ce_q : ok_q;
    assign start  = ~lframe_n & (lad_in == LAD_START) & ok_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= 1'b1;
            lf_q <= 1'b1;
            ok_q <= 1'b0;
        end else begin
            ce_q <= ce_n;
            lf_q <= lframe_n;
            ok_q <= ok_now;
        end
    end
endmodule

// File: rtl/lpc_window_decode.sv
`timescale 1ns/1ps
module lpc_window_decode #(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_LSB  = 22,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0] REG_BASE = 32'hFF80_0000,
    parameter int                TAG_W    = 4
)(
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  boot_tag,
    input  logic              tbl_n,
    input  logic              wp_n,
    output logic              mem_hit,
    output logic              reg_hit,
    output logic              boot_hit,
    output logic              blocked
);
    localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_LSB;

    assign mem_hit  = ((addr ^ MEM_BASE) & WIN_MASK) == '0;
    assign reg_hit  = ((addr ^ REG_BASE) & WIN_MASK) == '0;
    assign boot_hit = &boot_tag;
    assign blocked  = boot_hit ? ~tbl_n : ~wp_n;
endmodule

// File: rtl/lpc_access_gate.sv
`timescale 1ns/1ps
module lpc_access_gate
    import lpc_gate_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                WIN_LSB     = 22,
    parameter logic [ADDR_W-1:0] MEM_BASE    = 32'hFFC0_0000,
    parameter logic [ADDR_W-1:0] REG_BASE    = 32'hFF80_0000,
    parameter int                ARRAY_AW    = 18,
    parameter int                BOOT_AW     = 14,
    parameter int                SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              ce_n,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    input  logic              init_n,
    input  logic              rst_n,
    input  logic              tbl_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_vld,
    input  logic              op_req,
    input  logic              op_done,
    input  logic              cyc_end,
    input  logic              drv_req,
    output logic              cyc_start,
    output logic              mem_sel,
    output logic              reg_sel,
    output logic              op_grant,
    output logic              op_reject,
    output logic              op_abort,
    output logic              lad_oe,
    output logic              standby
);
    localparam int TAG_W = ARRAY_AW - BOOT_AW;

    gate_state_t      state_q, state_d;
    logic             rst_i, start_raw;
    logic             mem_hit, reg_hit, boot_hit, blocked;
    logic             mem_q, reg_q, grant_q, rej_q, abort_q;
    logic [TAG_W-1:0] tag_q;
    logic             in_write, frame_go, take_op, miss;

    lpc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk(clk), .init_n(init_n), .rst_n(rst_n), .rst_o(rst_i)
    );

    lpc_start_detect u_start (
        .clk(clk), .rst(rst_i), .ce_n(ce_n), .lframe_n(lframe_n),
        .lad_in(lad_in), .start(start_raw)
    );

    lpc_window_decode #(
        .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .MEM_BASE(MEM_BASE),
        .REG_BASE(REG_BASE), .TAG_W(TAG_W)
    ) u_dec (
        .addr(addr_in), .boot_tag(tag_q), .tbl_n(tbl_n), .wp_n(wp_n),
        .mem_hit(mem_hit), .reg_hit(reg_hit), .boot_hit(boot_hit),
        .blocked(blocked)
    );

    assign in_write = (state_q == ST_WRITING);
    assign frame_go = start_raw & ~in_write;
    assign miss     = addr_vld & ~mem_hit & ~reg_hit;
    assign take_op  = (state_q == ST_ACTIVE) & ~frame_go & ~addr_vld
                    & op_req & mem_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (frame_go) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (frame_go)     state_d = ST_ACTIVE;
                else if (miss)    state_d = ST_STANDBY;
                else if (take_op) state_d = blocked ? ST_STANDBY : ST_WRITING;
                else if (cyc_end) state_d = ST_STANDBY;
            end
            ST_WRITING: begin
                if (op_done) state_d = ST_STANDBY;
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst_i) state_q <= ST_STANDBY;
        else       state_q <= state_d;
    end

    // Cycle context and one-clock pulses
    always_ff @(posedge clk) begin
        if (rst_i) begin
            mem_q   <= 1'b0;
            reg_q   <= 1'b0;
            tag_q   <= '0;
            grant_q <= 1'b0;
            rej_q   <= 1'b0;
            abort_q <= in_write & ~op_done;
        end else begin
            grant_q <= take_op & ~blocked;
            rej_q   <= take_op & blocked;
            abort_q <= 1'b0;
            if (frame_go || state_d == ST_STANDBY) begin
                mem_q <= 1'b0;
                reg_q <= 1'b0;
            end else if (state_q == ST_ACTIVE && addr_vld) begin
                mem_q <= mem_hit;
                reg_q <= reg_hit;
                tag_q <= addr_in[ARRAY_AW-1:BOOT_AW];
            end
        end
    end

    // Outputs
    always_comb begin
        cyc_start = frame_go & ~rst_i;
        lad_oe    = drv_req & (state_q == ST_ACTIVE) & (mem_q | reg_q) & ~rst_i;
        standby   = (state_q == ST_STANDBY) & ce_n;
        mem_sel   = mem_q;
        reg_sel   = reg_q;
        op_grant  = grant_q;
        op_reject = rej_q;
        op_abort  = abort_q;
    end
endmodule

// File: rtl/lpc_access_gate_chk.sv
`timescale 1ns/1ps
module lpc_access_gate_chk (
    input logic clk,
    input logic rst_i,
    input logic ce_n,
    input logic lframe_n,
    input logic tbl_n,
    input logic wp_n,
    input logic cyc_start,
    input logic mem_sel,
    input logic reg_sel,
    input logic op_grant,
    input logic op_reject,
    input logic lad_oe,
    input logic boot_hit,
    input logic in_write
);
    assert_ce_lead_R1: assert property (@(posedge clk) disable iff (rst_i)
        (cyc_start && $past(lframe_n)) |-> !$past(ce_n));

    assert_sel_excl_R3: assert property (@(posedge clk) disable iff (rst_i)
        !(mem_sel && reg_sel));

    assert_boot_lock_R4: assert property (@(posedge clk) disable iff (rst_i)
        (op_grant && boot_hit) |-> $past(tbl_n));

    assert_main_lock_R5: assert property (@(posedge clk) disable iff (rst_i)
        (op_grant && !boot_hit) |-> $past(wp_n));

    assert_grant_pulse_R6: assert property (@(posedge clk) disable iff (rst_i)
        op_grant |=> !op_grant);

    assert_busy_no_start_R6: assert property (@(posedge clk) disable iff (rst_i)
        in_write |-> !cyc_start);

    assert_reject_pulse_R7: assert property (@(posedge clk) disable iff (rst_i)
        op_reject |=> !op_reject);

    assert_grant_reject_excl_R7: assert property (@(posedge clk) disable iff (rst_i)
        !(op_grant && op_reject));

    assert_oe_needs_sel_R12: assert property (@(posedge clk) disable iff (rst_i)
        lad_oe |-> (mem_sel || reg_sel));
endmodule

bind lpc_access_gate lpc_access_gate_chk u_chk (
    .clk(clk), .rst_i(rst_i), .ce_n(ce_n), .lframe_n(lframe_n),
    .tbl_n(tbl_n), .wp_n(wp_n), .cyc_start(cyc_start),
    .mem_sel(mem_sel), .reg_sel(reg_sel), .op_grant(op_grant),
    .op_reject(op_reject), .lad_oe(lad_oe), .boot_hit(boot_hit),
    .in_write(in_write)
);

// File: tb/lpc_access_gate_test.sv
`timescale 1ns/1ps
module lpc_access_gate_test;
    logic        clk = 1'b0;
    logic        ce_n = 1'b1, lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic        init_n = 1'b0, rst_n = 1'b0;
    logic        tbl_n = 1'b1, wp_n = 1'b1;
    logic [31:0] addr_in = '0;
    logic        addr_vld = 1'b0, op_req = 1'b0, op_done = 1'b0;
    logic        cyc_end = 1'b0, drv_req = 1'b0;
    logic        cyc_start, mem_sel, reg_sel, op_grant, op_reject;
    logic        op_abort, lad_oe, standby;

    int nchk = 0;
    int errs = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lpc_access_gate uut (
        .clk(clk), .ce_n(ce_n), .lframe_n(lframe_n), .lad_in(lad_in),
        .init_n(init_n), .rst_n(rst_n), .tbl_n(tbl_n), .wp_n(wp_n),
        .addr_in(addr_in), .addr_vld(addr_vld), .op_req(op_req),
        .op_done(op_done), .cyc_end(cyc_end), .drv_req(drv_req),
        .cyc_start(cyc_start), .mem_sel(mem_sel), .reg_sel(reg_sel),
        .op_grant(op_grant), .op_reject(op_reject), .op_abort(op_abort),
        .lad_oe(lad_oe), .standby(standby)
    );

    // {addr, tbl_n, wp_n, exp_mem, exp_reg, exp_grant, exp_reject}
    localparam int NV = 15;
    localparam logic [37:0] VEC [0:NV-1] = '{
        {32'hFFC0_0000, 6'b11_10_10},
        {32'hFFC0_0000, 6'b10_10_01},
        {32'hFFC0_0000, 6'b01_10_10},
        {32'hFFC3_BFFF, 6'b01_10_10},
        {32'hFFC3_BFFF, 6'b10_10_01},
        {32'hFFC3_C000, 6'b01_10_01},
        {32'hFFC3_C000, 6'b10_10_10},
        {32'hFFFF_FFFF, 6'b00_10_01},
        {32'hFFFF_FFFF, 6'b11_10_10},
        {32'hFFC7_C000, 6'b01_10_01},
        {32'hFFBF_FFFF, 6'b11_01_00},
        {32'hFF80_0000, 6'b00_01_00},
        {32'hFF7F_FFFF, 6'b11_00_00},
        {32'h0000_0000, 6'b11_00_00},
        {32'hFFC0_0000, 6'b00_10_01}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_frame();
        ce_n = 1'b0;
        tick();
        lframe_n = 1'b0;
        lad_in = 4'h0;
        #1 chk("R1 start after chip enable lead", cyc_start, 1);
        tick();
        lframe_n = 1'b1;
        lad_in = 4'hF;
    endtask

    task automatic grant_write(input logic [31:0] a);
        start_frame();
        addr_in = a; addr_vld = 1'b1;
        tick();
        addr_vld = 1'b0;
        op_req = 1'b1;
        tick();
        op_req = 1'b0;
        chk("R6 grant before write", op_grant, 1);
    endtask

    task automatic release_reset();
        init_n = 1'b1; rst_n = 1'b1;
        tick(); tick(); tick();
    endtask

    task automatic run_vec(input logic [37:0] v);
        start_frame();
        addr_in = v[37:6]; addr_vld = 1'b1;
        tick();
        addr_vld = 1'b0;
        chk("R3 mem_sel decode", mem_sel, v[3]);
        chk("R3 reg_sel decode", reg_sel, v[2]);
        tbl_n = v[5]; wp_n = v[4]; op_req = 1'b1;
        tick();
        op_req = 1'b0;
        chk("R4 R5 op_grant", op_grant, v[1]);
        chk("R4 R5 R7 op_reject", op_reject, v[0]);
        tick();
        chk("R6 grant one clock", op_grant, 0);
        chk("R7 reject one clock", op_reject, 0);
        op_done = 1'b1; cyc_end = 1'b1; ce_n = 1'b1;
        tick();
        op_done = 1'b0; cyc_end = 1'b0; tbl_n = 1'b1; wp_n = 1'b1;
        tick();
        chk("R11 standby after cycle", standby, 1);
    endtask

    initial begin
        #(4 * 50000);
        if (!finished) begin
            nchk++; errs++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        release_reset();

        // Reset state
        chk("R11 standby after reset", standby, 1);
        chk("R9 mem_sel after reset", mem_sel, 0);
        chk("R9 reg_sel after reset", reg_sel, 0);
        chk("R9 lad_oe after reset", lad_oe, 0);
        chk("R10 no abort after reset", op_abort, 0);
        chk("R7 no grant/reject after reset", {op_grant, op_reject}, 0);

        // Vector table
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // Chip enable too late: whole frame ignored
        lframe_n = 1'b0; ce_n = 1'b0; lad_in = 4'h0;
        #1 chk("R1 late chip enable no start", cyc_start, 0);
        tick();
        chk("R1 held frame still ignored", cyc_start, 0);
        chk("R11 no standby while ce low", standby, 0);
        lframe_n = 1'b1; lad_in = 4'hF;
        addr_in = 32'hFFC0_0000; addr_vld = 1'b1;
        tick();
        addr_vld = 1'b0;
        chk("R1 ignored frame selects nothing", mem_sel, 0);
        ce_n = 1'b1;
        tick();

        // Bad start code, then valid code in the same frame
        ce_n = 1'b0;
        tick();
        lframe_n = 1'b0; lad_in = 4'h2;
        #1 chk("R2 non-start code", cyc_start, 0);
        tick();
        lad_in = 4'h0;
        #1 chk("R2 start code later in frame", cyc_start, 1);
        tick();
        lframe_n = 1'b1; lad_in = 4'hF;
        cyc_end = 1'b1;
        tick();
        cyc_end = 1'b0;

        // Restart during ACTIVE, register read, then INIT# mid-read
        start_frame();
        addr_in = 32'hFFC0_0000; addr_vld = 1'b1;
        tick();
        addr_vld = 1'b0;
        chk("R8 mem_sel before restart", mem_sel, 1);
        lframe_n = 1'b0; lad_in = 4'h0;
        #1 chk("R8 restart start", cyc_start, 1);
        tick();
        lframe_n = 1'b1; lad_in = 4'hF;
        chk("R8 restart clears mem_sel", mem_sel, 0);
        addr_in = 32'hFF80_0000; addr_vld = 1'b1;
        tick();
        addr_vld = 1'b0;
        chk("R3 reg_sel after restart", reg_sel, 1);
        drv_req = 1'b1;
        #1 chk("R12 lad_oe follows drv_req", lad_oe, 1);
        tick();
        init_n = 1'b0;
        #1 chk("R9 init_n releases LAD", lad_oe, 0);
        tick();
        chk("R9 reset clears reg_sel", reg_sel, 0);
        chk("R10 no abort outside write", op_abort, 0);
        drv_req = 1'b0; ce_n = 1'b1;
        release_reset();
        chk("R9 standby after init_n release", standby, 1);

        // Frames and lock pins ignored during write
        grant_write(32'hFFC3_C000);
        tbl_n = 1'b0; wp_n = 1'b0;
        lframe_n = 1'b0; lad_in = 4'h0;
        #1 chk("R6 no start while writing", cyc_start, 0);
        tick();
        lframe_n = 1'b1; lad_in = 4'hF; ce_n = 1'b1;
        chk("R6 pin change no reject", op_reject, 0);
        chk("R6 pin change no abort", op_abort, 0);
        tick();
        chk("R6 still writing", standby, 0);
        chk("R6 select held during write", mem_sel, 1);
        op_done = 1'b1;
        tick();
        op_done = 1'b0; tbl_n = 1'b1; wp_n = 1'b1;
        chk("R11 standby after write done", standby, 1);

        // Reset aborts a write
        grant_write(32'hFFC0_0000);
        ce_n = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        chk("R10 abort pulse", op_abort, 1);
        chk("R9 standby after reset in write", standby, 1);
        tick();
        chk("R10 abort one clock", op_abort, 0);
        release_reset();

        // Reset in the same clock as write completion
        grant_write(32'hFFC0_0000);
        ce_n = 1'b1;
        tick();
        rst_n = 1'b0; op_done = 1'b1;
        tick();
        op_done = 1'b0;
        chk("R10 completed write not aborted", op_abort, 0);
        chk("R9 standby after reset at done", standby, 1);
        release_reset();

        // Operation resumes after RST# release
        ce_n = 1'b0;
        tick();
        lframe_n = 1'b0; lad_in = 4'h0;
        #1 chk("R9 start after release", cyc_start, 1);
        tick();
        lframe_n = 1'b1; lad_in = 4'hF; cyc_end = 1'b1; ce_n = 1'b1;
        tick();
        cyc_end = 1'b0;
        chk("R11 standby final", standby, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule